// File: doc/BRIEF.md
# Byte-Count SPI Master with Shared Transfer Buffer

This block is an SPI master that moves a block of bytes between a small on-chip byte buffer and one SPI target. Software first fills the buffer through a simple register port, then writes a single command word that carries a total byte count, a drive byte count and a chip-select release flag. The engine lowers chip select, runs eight SCLK cycles for every byte of the total, and sends byte i from buffer slot i, most significant bit first. Each byte sampled on MISO is written back into the slot it was sent from, so when the transfer ends the buffer holds the target's reply in place.

The serial clock comes from the system clock through a programmable half-period divider. The bus uses SPI mode 0: SCLK idles low, MOSI changes on falling edges, and MISO is sampled on rising edges. Two status bits report progress. Busy covers the time from command acceptance to the release of the bus. A sticky done flag stays set until the next accepted command.

Top module: `spi_blk_master`

## Requirements
- R1: After synchronous reset, `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0, and the status register reads 0.
- R2: Register map, with read data appearing one clock after the address is presented. Addresses 0 to DEPTH-1 are buffer slots in data bits [7:0]. Address 0x20 is the command register: total count in bits [7:0], drive count in bits [15:8], release flag in bit 20, and reads return the last accepted word with the clamped counts. Address 0x21 is status: bit 0 is busy and bit 1 is done.
- R3: An accepted command with total count N (N at least 1) produces exactly 8×N rising SCLK edges. SCLK is low whenever the engine is idle.
- R4: The bit on MOSI at rising edge 8·i+b is bit 7−b of buffer slot i, for every byte of the total. This holds whatever the drive count is.
- R5: The byte sampled on MISO for byte i, MSB first on rising edges, replaces buffer slot i. Slots at or beyond the total count are left untouched.
- R6: Chip select falls exactly H system clocks before the first rising SCLK edge. With the release flag set, it rises exactly H clocks after the last falling SCLK edge.
- R7: With the release flag clear, chip select stays asserted after the transfer completes, until a later command that has the flag set completes.
- R8: The SCLK half-period is H = max(`cfg_half_div`, 1) system clocks, captured at the start of each transfer, so the SCLK period is 2·H.
- R9: A command with a total count of 0 produces no SCLK edges, does not set busy, and sets done.
- R10: A total count above DEPTH is clamped to DEPTH. A drive count above the (clamped) total is clamped to the total.
- R11: While busy, writes to the command register and to buffer slots are ignored.
- R12: Busy reads 1 from the clock after command acceptance until the bus is released. Done is cleared by the next accepted command and set when that command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one clock after the address |
| cfg_half_div | input | DIV_W | SCLK half-period in system clocks (0 is treated as 1) |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |

## Verification
The main transfer is exercised with several combinations of total count, drive count and divider: a drive count equal to the total, a drive count below it, a single byte, nine bytes, and the full buffer at the fastest divider. Each pattern preloads buffer contents that differ from what the target model returns. This separates an in-place MISO write-back from a loopback of MOSI, and shows that trailing bytes still drive their slot contents. Measuring the SCLK edges against the chip-select edges at different dividers catches off-by-one errors in the lead time, the tail time and the half-period. Directed cases cover a zero total, oversized counts, writes while busy, and a held chip select.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int REG_AW = 6;
  localparam logic [REG_AW-1:0] CMD_ADDR  = 6'h20;
  localparam logic [REG_AW-1:0] STAT_ADDR = 6'h21;
  localparam int TOT_LSB = 0;
  localparam int TX_LSB  = 8;
  localparam int REL_BIT = 20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LOAD, ST_LEAD, ST_HIGH, ST_LOW, ST_TAIL
  } spim_state_e;
endpackage

// File: rtl/spim_clkgen.sv
`timescale 1ns/1ps
module spim_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] half_cfg,
  output logic             tick
);
  logic [DIV_W-1:0] lim_q, cnt_q;

  // lim_q = H - 1; the divider setting is captured on restart
  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (restart) begin
      lim_q <= (half_cfg == '0) ? '0 : half_cfg - DIV_W'(1);
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + DIV_W'(1);
    end
  end

  assign tick = run && (cnt_q == lim_q);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim_q); // R8
endmodule

// File: rtl/spim_buf.sv
`timescale 1ns/1ps
module spim_buf #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic [AW-1:0] b_raddr,
  output logic [7:0]    b_rdata,
  input  logic [AW-1:0] b_waddr,
  input  logic          b_we,
  input  logic [7:0]    b_wdata
);
  logic [7:0] mem [DEPTH];

  // one write port; the two writers are never active in the same cycle
  always_ff @(posedge clk) begin
    if (b_we)      mem[b_waddr] <= b_wdata;
    else if (a_we) mem[a_addr]  <= a_wdata;
  end

  always_ff @(posedge clk) begin
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_raddr];
  end
endmodule

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl
  import spim_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int BW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] total,
  input  logic          release_cs,
  input  logic          tick,
  input  logic [7:0]    rd_data,
  input  logic          miso,
  output logic          restart,
  output logic          run,
  output logic [BW-1:0] rd_addr,
  output logic          wr_en,
  output logic [BW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          busy,
  output logic          done,
  output logic          sclk,
  output logic          cs_n,
  output logic          mosi
);
  spim_state_e   state_q;
  logic [BW-1:0] idx_q, idx_next;
  logic [3:0]    bits_q;
  logic [6:0]    tx_sr;
  logic [7:0]    rx_sr;
  logic [CW-1:0] tot_q;
  logic          rel_q;
  logic          last_byte;

  assign idx_next  = (idx_q == BW'(DEPTH - 1)) ? '0 : idx_q + BW'(1);
  assign last_byte = (CW'(idx_q) + CW'(1)) == tot_q;
  // prefetch the next slot so it is ready at the byte boundary
  assign rd_addr   = (state_q == ST_FETCH) ? idx_q : idx_next;
  assign restart   = (state_q == ST_LOAD);
  assign run       = (state_q == ST_LEAD) || (state_q == ST_HIGH) ||
                     (state_q == ST_LOW)  || (state_q == ST_TAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      bits_q  <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      tot_q   <= '0;
      rel_q   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          done <= 1'b0;
          if (total == '0) begin
            done <= 1'b1;
          end else begin
            busy    <= 1'b1;
            tot_q   <= total;
            rel_q   <= release_cs;
            idx_q   <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          tx_sr   <= rd_data[6:0];
          mosi    <= rd_data[7];
          cs_n    <= 1'b0;
          bits_q  <= '0;
          state_q <= ST_LEAD;
        end
        ST_LEAD, ST_LOW: if (tick) begin
          sclk    <= 1'b1;
          rx_sr   <= {rx_sr[6:0], miso};
          bits_q  <= bits_q + 4'd1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk <= 1'b0;
          if (bits_q == 4'd8) begin
            wr_en   <= 1'b1;
            wr_addr <= idx_q;
            wr_data <= rx_sr;
            bits_q  <= '0;
            if (last_byte) begin
              state_q <= ST_TAIL;
            end else begin
              idx_q   <= idx_next;
              tx_sr   <= rd_data[6:0];
              mosi    <= rd_data[7];
              state_q <= ST_LOW;
            end
          end else begin
            mosi    <= tx_sr[6];
            tx_sr   <= {tx_sr[5:0], 1'b0};
            state_q <= ST_LOW;
          end
        end
        ST_TAIL: if (tick) begin
          if (rel_q) cs_n <= 1'b1;
          mosi    <= 1'b0;
          busy    <= 1'b0;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n); // R6
  AST_IDLE_NO_SCLK: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk); // R3
  AST_DONE_EXCL_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R12
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (CW'(idx_q) < tot_q)); // R10
  AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    bits_q <= 4'd8); // R3
endmodule

// File: rtl/spi_blk_master.sv
`timescale 1ns/1ps
module spi_blk_master
  import spim_pkg::*;
#(
  parameter  int DEPTH = 16,   // 9 to 32 slots, fits below CMD_ADDR
  parameter  int DIV_W = 8,
  localparam int BW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [DIV_W-1:0]  cfg_half_div,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic              cmd_wr, accept, buf_we, in_buf;
  logic [7:0]        tot_raw, tx_raw, tot_cl, tx_cl;
  logic [31:0]       cmd_q;
  logic [REG_AW-1:0] addr_q;
  logic              busy, done, tick, restart, run;
  logic [BW-1:0]     eng_raddr, eng_waddr;
  logic [7:0]        eng_rdata, eng_wdata, a_rdata;
  logic              eng_we;

  assign in_buf  = reg_addr < REG_AW'(DEPTH);
  assign cmd_wr  = reg_wr && (reg_addr == CMD_ADDR);
  assign accept  = cmd_wr && !busy;
  assign buf_we  = reg_wr && in_buf && !busy;

  assign tot_raw = reg_wdata[TOT_LSB +: 8];
  assign tx_raw  = reg_wdata[TX_LSB +: 8];
  assign tot_cl  = (tot_raw > 8'(DEPTH)) ? 8'(DEPTH) : tot_raw;
  assign tx_cl   = (tx_raw > tot_cl) ? tot_cl : tx_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      addr_q <= '0;
    end else begin
      addr_q <= reg_addr;
      if (accept) cmd_q <= {reg_wdata[31:16], tx_cl, tot_cl};
    end
  end

  always_comb begin
    if (addr_q == CMD_ADDR)               reg_rdata = cmd_q;
    else if (addr_q == STAT_ADDR)         reg_rdata = {30'd0, done, busy};
    else if (addr_q < REG_AW'(DEPTH))     reg_rdata = {24'd0, a_rdata};
    else                                  reg_rdata = '0;
  end

  spim_buf #(.DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .a_addr  (reg_addr[BW-1:0]),
    .a_we    (buf_we),
    .a_wdata (reg_wdata[7:0]),
    .a_rdata (a_rdata),
    .b_raddr (eng_raddr),
    .b_rdata (eng_rdata),
    .b_waddr (eng_waddr),
    .b_we    (eng_we),
    .b_wdata (eng_wdata)
  );

  spim_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .run      (run),
    .half_cfg (cfg_half_div),
    .tick     (tick)
  );

  spim_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .total      (CW'(tot_cl)),
    .release_cs (reg_wdata[REL_BIT]),
    .tick       (tick),
    .rd_data    (eng_rdata),
    .miso       (spi_miso),
    .restart    (restart),
    .run        (run),
    .rd_addr    (eng_raddr),
    .wr_en      (eng_we),
    .wr_addr    (eng_waddr),
    .wr_data    (eng_wdata),
    .busy       (busy),
    .done       (done),
    .sclk       (spi_sclk),
    .cs_n       (spi_cs_n),
    .mosi       (spi_mosi)
  );

  AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr) |=> $stable(cmd_q)); // R11
  AST_ENG_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> busy); // R5
  AST_NO_SHARED_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(eng_we && buf_we)); // R11
endmodule

// File: tb/spi_blk_master_bench.sv
`timescale 1ns/1ps
module spi_blk_master_bench;
  localparam int DEPTH = 16;
  localparam int DIV_W = 8;
  localparam logic [5:0] CMD  = 6'h20;
  localparam logic [5:0] STAT = 6'h21;
  localparam realtime TCLK = 8.0;

  // {seed, divider, drive count, total count}
  localparam logic [31:0] VEC [6] = '{
    {8'd1, 8'd2, 8'd3,  8'd3},
    {8'd2, 8'd1, 8'd3,  8'd4},
    {8'd3, 8'd3, 8'd2,  8'd3},
    {8'd4, 8'd1, 8'd1,  8'd1},
    {8'd5, 8'd2, 8'd9,  8'd9},
    {8'd6, 8'd0, 8'd5,  8'd16}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic [5:0]       reg_addr;
  logic             reg_wr;
  logic [31:0]      reg_wdata;
  logic [31:0]      reg_rdata;
  logic [DIV_W-1:0] cfg_half_div;
  logic             spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  always #4 clk = ~clk;

  spi_blk_master #(.DEPTH(DEPTH), .DIV_W(DIV_W)) u_spi_blk_master (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_half_div(cfg_half_div),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [7:0] pre_byte(int seed, int j);
    return 8'(seed * 13 + j * 29 + 1);
  endfunction
  function automatic logic [7:0] slv_byte(int seed, int j);
    return 8'((seed * 37 + j * 11) ^ 8'h5A);
  endfunction
  function automatic logic slv_bit(int seed, int k);
    logic [7:0] b;
    if (k < 0 || k >= 256) return 1'b0;
    b = slv_byte(seed, k / 8);
    return b[7 - (k % 8)];
  endfunction

  // bus monitor and target model (MISO changes after each falling edge)
  int rise_cnt = 0, fall_cnt = 0, rise_base = 0, fall_base = 0, cur_seed = 0;
  logic mcap [512];
  realtime t_first, t_second, t_lastfall, t_csfall, t_csrise;

  assign spi_miso = slv_bit(cur_seed, fall_cnt - fall_base);

  always @(posedge spi_sclk) begin
    int r;
    r = rise_cnt - rise_base;
    if (r == 0) t_first = $realtime;
    if (r == 1) t_second = $realtime;
    if (r >= 0 && r < 512) mcap[r] = spi_mosi;
    rise_cnt++;
  end
  always @(negedge spi_sclk) begin
    fall_cnt++;
    t_lastfall = $realtime;
  end
  always @(negedge spi_cs_n) t_csfall = $realtime;
  always @(posedge spi_cs_n) t_csrise = $realtime;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    do reg_read(STAT, s); while (s[1] !== 1'b1);
  endtask

  task automatic start_cmd(input int seed, input int tot, input int tx, input int div, input bit rel);
    @(negedge clk);
    cur_seed = seed; rise_base = rise_cnt; fall_base = fall_cnt;
    cfg_half_div = DIV_W'(div);
    reg_write(CMD, {11'd0, rel, 4'd0, 8'(tx), 8'(tot)});
  endtask

  function automatic longint ps(realtime t);
    return longint'(t * 1000.0);
  endfunction

  initial begin
    #1_200_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; cfg_half_div = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && spi_mosi === 1'b0, "R1 pins",
          {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
    reg_read(STAT, d);
    check(d === 32'd0, "R1 status", d, 0);

    // table-driven transfers
    for (int v = 0; v < 6; v++) begin
      int seed, div, tx, tot, h, mism;
      {seed, div, tx, tot} = {24'd0, VEC[v][31:24], 24'd0, VEC[v][23:16],
                              24'd0, VEC[v][15:8], 24'd0, VEC[v][7:0]};
      h = (div == 0) ? 1 : div;
      for (int j = 0; j < DEPTH; j++) reg_write(6'(j), {24'd0, pre_byte(seed, j)});
      start_cmd(seed, tot, tx, div, 1'b1);
      wait_done();
      check(rise_cnt - rise_base == 8 * tot, "R3 sclk count", rise_cnt - rise_base, 8 * tot);
      mism = 0;
      for (int r = 0; r < 8 * tot; r++) begin
        logic [7:0] e;
        e = pre_byte(seed, r / 8);
        if (mcap[r] !== e[7 - (r % 8)]) mism++;
      end
      check(mism == 0, "R4 mosi bits from slots", mism, 0);
      for (int j = 0; j < tot; j++) begin
        reg_read(6'(j), d);
        check(d[7:0] === slv_byte(seed, j), "R5 slot holds miso byte", d[7:0], slv_byte(seed, j));
      end
      if (tot < DEPTH) begin
        reg_read(6'(tot), d);
        check(d[7:0] === pre_byte(seed, tot), "R5 slot past total kept", d[7:0], pre_byte(seed, tot));
      end
      check(spi_cs_n === 1'b1, "R6 cs released", spi_cs_n, 1);
      check(ps(t_first - t_csfall) == ps(h * TCLK), "R6 lead time",
            ps(t_first - t_csfall), ps(h * TCLK));
      check(ps(t_csrise - t_lastfall) == ps(h * TCLK), "R6 tail time",
            ps(t_csrise - t_lastfall), ps(h * TCLK));
      check(ps(t_second - t_first) == ps(2 * h * TCLK), "R8 sclk period",
            ps(t_second - t_first), ps(2 * h * TCLK));
      reg_read(CMD, d);
      check(d[15:8] == 8'(tx) && d[7:0] == 8'(tot), "R2 command readback", d[15:0], {8'(tx), 8'(tot)});
    end

    // R9: zero total
    start_cmd(9, 0, 0, 1, 1'b1);
    reg_read(STAT, d);
    check(d === 32'd2, "R9 done without busy", d, 2);
    repeat (20) @(negedge clk);
    check(rise_cnt - rise_base == 0, "R9 no sclk", rise_cnt - rise_base, 0);

    // R10: clamping of both counts
    start_cmd(7, 20, 30, 1, 1'b1);
    wait_done();
    check(rise_cnt - rise_base == 8 * DEPTH, "R10 total clamp edges", rise_cnt - rise_base, 8 * DEPTH);
    reg_read(CMD, d);
    check(d[15:0] === {8'(DEPTH), 8'(DEPTH)}, "R10 clamped fields", d[15:0], {8'(DEPTH), 8'(DEPTH)});

    // R11 and R12: writes while busy, status after acceptance
    reg_write(6'd10, 32'h3C);
    start_cmd(8, 2, 2, 3, 1'b1);
    reg_read(STAT, d);
    check(d === 32'd1, "R12 busy set done cleared", d, 1);
    reg_write(CMD, {11'd0, 1'b1, 4'd0, 8'd5, 8'd5});
    reg_write(6'd10, 32'hEE);
    wait_done();
    check(rise_cnt - rise_base == 16, "R11 command while busy ignored", rise_cnt - rise_base, 16);
    reg_read(6'd10, d);
    check(d[7:0] === 8'h3C, "R11 slot write while busy ignored", d[7:0], 8'h3C);
    reg_read(CMD, d);
    check(d[7:0] === 8'd2, "R11 command readback unchanged", d[7:0], 2);
    reg_read(STAT, d);
    check(d === 32'd2, "R12 done after completion", d, 2);

    // R7: held chip select
    start_cmd(11, 1, 1, 1, 1'b0);
    wait_done();
    repeat (10) @(negedge clk);
    check(spi_cs_n === 1'b0, "R7 cs held", spi_cs_n, 0);
    start_cmd(12, 1, 1, 1, 1'b1);
    wait_done();
    check(spi_cs_n === 1'b1, "R7 cs released later", spi_cs_n, 1);
    check(rise_cnt - rise_base == 8, "R3 single byte edges", rise_cnt - rise_base, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule